// File: doc/BRIEF.md
# PCI Posted Write Combiner

This block sits between a processor-side write request port and a PCI master request port. It gathers consecutive posted memory writes into a local buffer. It hands them on as one longer burst, so the PCI side pays for one address phase in place of one per write. Each request carries a 32-bit address, a 4-bit PCI command code, one 64-bit data beat, eight byte enables and an ordering-barrier flag. Each emitted burst carries a start address, the command, a beat count and a stream of data beats, each with its own byte enables.

A write extends the open burst only under these conditions. It must be a memory-write-class command, the same command as the burst, beat-aligned, at the next ascending 8-byte address, and not flagged as a barrier. Any other write first causes the open burst to be emitted, then starts a burst of its own. The open burst is also emitted when the buffer is full or when the input has been quiet for a fixed number of cycles. While a burst is being emitted, the input port is held off.

Top module: `pwc_top`

## Requirements
- R1: Only command codes 4'b0111 (memory write) and 4'b1111 (memory write and invalidate) can be merged. Any other command code is emitted as its own burst of length 1, even when its address is contiguous.
- R2: A write joins the open burst when its address equals the burst start address plus 8 times the current beat count. Such writes form one burst whose beat count is the number of writes joined.
- R3: A write whose address is below the open burst's next address, or that otherwise breaks contiguity, is not merged. The open burst is emitted first and the write starts a new burst.
- R4: A write to an address already held in the open burst is not merged. The open burst is emitted with its original data and byte enables, followed by a new burst holding the new write.
- R5: A request with the barrier flag set never joins the preceding burst. The open burst is emitted before that request is accepted.
- R6: A burst holds at most 8 beats. On the 8th accepted beat it is emitted without waiting, and the next contiguous write starts a new burst.
- R7: When a burst is open and no write is presented for 16 consecutive clock edges after the last accepted write, the burst is emitted. out_valid rises after the 16th such edge and not before.
- R8: A change between command 4'b0111 and 4'b1111 at a contiguous address closes the open burst. The new write starts a new burst.
- R9: An emitted burst presents out_addr equal to the first write's address and out_cmd and out_len constant over all beats. Beats come in acceptance order with their own byte enables, and out_last is set only on the final beat. All outputs hold while out_ready is low.
- R10: in_ready is low in every cycle in which a burst is being emitted (out_valid high).
- R11: A memory write whose address bits [2:0] are not zero is emitted alone as a burst of length 1.
- R12: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Write request present |
| in_ready | output | 1 | Write request accepted on this edge when in_valid is high |
| in_addr | input | ADDR_W | Byte address of the write |
| in_cmd | input | 4 | PCI command code |
| in_data | input | 64 | Data beat |
| in_be | input | 8 | Byte enables of the beat, active high |
| in_barrier | input | 1 | Ordering barrier: this write may not join the preceding ones |
| out_valid | output | 1 | A burst beat is presented |
| out_ready | input | 1 | Downstream takes the beat on this edge |
| out_addr | output | ADDR_W | Start address of the burst |
| out_cmd | output | 4 | Command of the burst |
| out_len | output | clog2(MAX_BEATS+1) | Beat count of the burst |
| out_data | output | 64 | Current data beat |
| out_be | output | 8 | Byte enables of the current beat |
| out_last | output | 1 | Final beat of the burst |

## Verification
The bench builds the block with its defaults: an 8-beat buffer, a 16-cycle idle limit and 32-bit addresses. With these values, bursts long enough to hit the full flush, and several bursts back to back, come up within a few hundred random writes. The idle limit is short enough to time exactly in a directed case. The random stream keeps gaps between writes well under the idle limit, so burst boundaries there depend only on address, command, alignment and barrier rules. Random output stalls exercise the hold behaviour of every beat.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    localparam int DATA_W     = 64;
    localparam int BE_W       = DATA_W / 8;
    localparam int BEAT_SHIFT = $clog2(BE_W);

    localparam logic [3:0] CMD_MEMWR = 4'b0111;
    localparam logic [3:0] CMD_MWINV = 4'b1111;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } beat_t;

    typedef enum logic {
        ST_GATHER,
        ST_DRAIN
    } wc_state_e;

    function automatic logic cmd_is_mergeable(input logic [3:0] cmd);
        return (cmd == CMD_MEMWR) || (cmd == CMD_MWINV);
    endfunction

endpackage

// File: rtl/wc_beat_store.sv
module wc_beat_store
    import pwc_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  beat_t            wr_beat,
    input  logic [IDX_W-1:0] rd_idx,
    output beat_t            rd_beat
);

    beat_t slots [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                slots[i] <= wr_beat;
            end
        end
    end

    assign rd_beat = slots[rd_idx];

endmodule

// File: rtl/wc_idle_timer.sv
module wc_idle_timer #(
    parameter int LIMIT = 16,
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);

    logic [CNT_W-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            quiet_q <= '0;
        end else if (!expire) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    assign expire = run && (quiet_q == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/wc_join_check.sv
module wc_join_check
    import pwc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 4
) (
    input  logic              open,
    input  logic [ADDR_W-1:0] base,
    input  logic [3:0]        cur_cmd,
    input  logic [LEN_W-1:0]  cur_len,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_cmd,
    input  logic              req_barrier,
    output logic              mergeable,
    output logic              joins
);

    logic [ADDR_W:0] next_addr;
    logic            aligned;

    always_comb begin
        next_addr = {1'b0, base} + ({{(ADDR_W + 1 - LEN_W){1'b0}}, cur_len} << BEAT_SHIFT);
        aligned   = (req_addr[BEAT_SHIFT-1:0] == '0);
        mergeable = cmd_is_mergeable(req_cmd) && aligned;
        joins     = open && mergeable && !req_barrier &&
                    (req_cmd == cur_cmd) &&
                    ({1'b0, req_addr} == next_addr);
    end

endmodule

// File: rtl/pwc_top.sv
module pwc_top
    import pwc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int MAX_BEATS  = 8,
    parameter int IDLE_LIMIT = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic [ADDR_W-1:0]              in_addr,
    input  logic [3:0]                     in_cmd,
    input  logic [DATA_W-1:0]              in_data,
    input  logic [BE_W-1:0]                in_be,
    input  logic                           in_barrier,
    output logic                           out_valid,
    input  logic                           out_ready,
    output logic [ADDR_W-1:0]              out_addr,
    output logic [3:0]                     out_cmd,
    output logic [$clog2(MAX_BEATS+1)-1:0] out_len,
    output logic [DATA_W-1:0]              out_data,
    output logic [BE_W-1:0]                out_be,
    output logic                           out_last
);

    localparam int LEN_W = $clog2(MAX_BEATS + 1);
    localparam int IDX_W = $clog2(MAX_BEATS);

    wc_state_e         state_q;
    logic [ADDR_W-1:0] base_q;
    logic [3:0]        cmd_q;
    logic [LEN_W-1:0]  len_q;
    logic [IDX_W-1:0]  rd_q;

    logic             open;
    logic             accept;
    logic             mergeable;
    logic             joins;
    logic             idle_run;
    logic             idle_expire;
    logic             rd_at_end;
    logic [LEN_W-1:0] len_m1;
    logic [IDX_W-1:0] wr_idx;
    beat_t            wr_beat;
    beat_t            rd_beat;

    assign open      = (state_q == ST_GATHER) && (len_q != '0);
    assign in_ready  = (state_q == ST_GATHER) && (!open || joins);
    assign accept    = in_valid && in_ready;
    assign idle_run  = open && !in_valid;
    assign len_m1    = len_q - 1'b1;
    assign rd_at_end = (LEN_W'(rd_q) == len_m1);
    assign wr_idx    = open ? len_q[IDX_W-1:0] : '0;
    assign wr_beat   = '{data: in_data, be: in_be};

    wc_join_check #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_join (
        .open        (open),
        .base        (base_q),
        .cur_cmd     (cmd_q),
        .cur_len     (len_q),
        .req_addr    (in_addr),
        .req_cmd     (in_cmd),
        .req_barrier (in_barrier),
        .mergeable   (mergeable),
        .joins       (joins)
    );

    wc_idle_timer #(
        .LIMIT (IDLE_LIMIT)
    ) u_idle (
        .clk    (clk),
        .rst    (rst),
        .run    (idle_run),
        .expire (idle_expire)
    );

    wc_beat_store #(
        .DEPTH (MAX_BEATS)
    ) u_store (
        .clk     (clk),
        .wr_en   (accept),
        .wr_idx  (wr_idx),
        .wr_beat (wr_beat),
        .rd_idx  (rd_q),
        .rd_beat (rd_beat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_GATHER;
            base_q  <= '0;
            cmd_q   <= '0;
            len_q   <= '0;
            rd_q    <= '0;
        end else begin
            unique case (state_q)
                ST_GATHER: begin
                    rd_q <= '0;
                    if (accept) begin
                        if (!open) begin
                            base_q <= in_addr;
                            cmd_q  <= in_cmd;
                            len_q  <= LEN_W'(1);
                            if (!mergeable) begin
                                state_q <= ST_DRAIN;
                            end
                        end else begin
                            len_q <= len_q + 1'b1;
                            if (len_q == LEN_W'(MAX_BEATS - 1)) begin
                                state_q <= ST_DRAIN;
                            end
                        end
                    end else if (open && (in_valid || idle_expire)) begin
                        state_q <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (out_ready) begin
                        if (rd_at_end) begin
                            state_q <= ST_GATHER;
                            len_q   <= '0;
                            rd_q    <= '0;
                        end else begin
                            rd_q <= rd_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_GATHER;
            endcase
        end
    end

    assign out_valid = (state_q == ST_DRAIN);
    assign out_addr  = base_q;
    assign out_cmd   = cmd_q;
    assign out_len   = len_q;
    assign out_data  = rd_beat.data;
    assign out_be    = rd_beat.be;
    assign out_last  = out_valid && rd_at_end;

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker
    import pwc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_BEATS = 8,
    localparam int LEN_W    = $clog2(MAX_BEATS + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic [3:0]        out_cmd,
    input logic [LEN_W-1:0]  out_len,
    input logic [DATA_W-1:0] out_data,
    input logic [BE_W-1:0]   out_be,
    input logic              out_last
);

    assert_reset_idle_R12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

    assert_input_held_off_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_be) &&
                                       $stable(out_addr) && $stable(out_last)));

    assert_header_steady_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last) |=> (out_valid && $stable(out_addr) &&
                                                   $stable(out_cmd) && $stable(out_len)));

    assert_len_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_len != '0) && (out_len <= LEN_W'(MAX_BEATS))));

    assert_multi_beat_cmd_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_len > LEN_W'(1))) |-> ((out_cmd == CMD_MEMWR) || (out_cmd == CMD_MWINV)));

    assert_multi_beat_aligned_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_len > LEN_W'(1))) |-> (out_addr[BEAT_SHIFT-1:0] == '0));

endmodule

bind pwc_top pwc_checker #(
    .ADDR_W    (ADDR_W),
    .MAX_BEATS (MAX_BEATS)
) u_pwc_checker (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_cmd   (out_cmd),
    .out_len   (out_len),
    .out_data  (out_data),
    .out_be    (out_be),
    .out_last  (out_last)
);

// File: tb/pwc_top_test.sv
`timescale 1ns/1ps
module pwc_top_test;

    localparam int ADDR_W = 32;
    localparam int MAXB   = 8;
    localparam int LEN_W  = $clog2(MAXB + 1);

    typedef struct {
        logic [31:0] addr;
        logic [3:0]  cmd;
        int          len;
        logic [63:0] data;
        logic [7:0]  be;
        logic        last;
    } exp_beat_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [31:0]       in_addr = '0;
    logic [3:0]        in_cmd = '0;
    logic [63:0]       in_data = '0;
    logic [7:0]        in_be = '0;
    logic              in_barrier = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [31:0]       out_addr;
    logic [3:0]        out_cmd;
    logic [LEN_W-1:0]  out_len;
    logic [63:0]       out_data;
    logic [7:0]        out_be;
    logic              out_last;

    int    total = 0;
    int    bad = 0;
    int    rdy_mode = 2;
    string cur_req = "R12";

    exp_beat_t   exp_q[$];
    logic [63:0] m_data [MAXB];
    logic [7:0]  m_be [MAXB];
    int          m_cnt = 0;
    logic [31:0] m_addr = '0;
    logic [3:0]  m_cmd = '0;

    always #2.5 clk = ~clk;

    pwc_top #(
        .ADDR_W     (ADDR_W),
        .MAX_BEATS  (MAXB),
        .IDLE_LIMIT (16)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_addr    (in_addr),
        .in_cmd     (in_cmd),
        .in_data    (in_data),
        .in_be      (in_be),
        .in_barrier (in_barrier),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_addr   (out_addr),
        .out_cmd    (out_cmd),
        .out_len    (out_len),
        .out_data   (out_data),
        .out_be     (out_be),
        .out_last   (out_last)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic model_mergeable(input logic [31:0] a, input logic [3:0] c);
        return ((c == 4'b0111) || (c == 4'b1111)) && (a[2:0] == 3'b000);
    endfunction

    task automatic model_close();
        for (int i = 0; i < m_cnt; i++) begin
            exp_beat_t e;
            e.addr = m_addr;
            e.cmd  = m_cmd;
            e.len  = m_cnt;
            e.data = m_data[i];
            e.be   = m_be[i];
            e.last = (i == m_cnt - 1);
            exp_q.push_back(e);
        end
        m_cnt = 0;
    endtask

    task automatic model_write(input logic [31:0] a, input logic [3:0] c,
                               input logic [63:0] d, input logic [7:0] b, input logic bar);
        logic        mrg;
        logic        jn;
        logic [32:0] nxt;
        mrg = model_mergeable(a, c);
        nxt = {1'b0, m_addr} + 33'(m_cnt * 8);
        jn  = (m_cnt > 0) && mrg && (c == m_cmd) && !bar && ({1'b0, a} == nxt);
        if ((m_cnt > 0) && !jn) model_close();
        if (m_cnt == 0) begin
            m_addr = a;
            m_cmd  = c;
        end
        m_data[m_cnt] = d;
        m_be[m_cnt]   = b;
        m_cnt++;
        if (!mrg || (m_cnt == MAXB)) model_close();
    endtask

    task automatic send(input logic [31:0] a, input logic [3:0] c,
                        input logic [63:0] d, input logic [7:0] b, input logic bar);
        @(negedge clk);
        model_write(a, c, d, b, bar);
        in_addr    = a;
        in_cmd     = c;
        in_data    = d;
        in_be      = b;
        in_barrier = bar;
        in_valid   = 1'b1;
        #0.5;
        while (!in_ready) begin
            @(negedge clk);
            #0.5;
        end
        @(posedge clk);
        #0.1;
        in_valid = 1'b0;
    endtask

    task automatic settle(input int cycles);
        model_close();
        repeat (cycles) @(negedge clk);
    endtask

    // Output monitor: every beat handed over is compared with the model (R9 and the phase tag)
    initial begin
        forever begin
            @(negedge clk);
            case (rdy_mode)
                0:       out_ready = 1'b0;
                1:       out_ready = 1'b1;
                default: out_ready = ($urandom_range(0, 3) != 0);
            endcase
            #0.5;
            if (!rst && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_req, "unexpected beat addr", 64'(out_addr), 64'hx);
                end else begin
                    exp_beat_t e;
                    e = exp_q.pop_front();
                    check(out_addr == e.addr, cur_req, "burst start address", 64'(out_addr), 64'(e.addr));
                    check(out_cmd == e.cmd, cur_req, "burst command", 64'(out_cmd), 64'(e.cmd));
                    check(int'(out_len) == e.len, cur_req, "burst length", 64'(out_len), 64'(e.len));
                    check(out_data == e.data, cur_req, "beat data", out_data, e.data);
                    check(out_be == e.be, cur_req, "beat byte enables", 64'(out_be), 64'(e.be));
                    check(out_last == e.last, cur_req, "last flag", 64'(out_last), 64'(e.last));
                end
            end
        end
    end

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        int unsigned seed;
        logic [31:0] ra;
        logic [3:0]  rc;
        int          pick;
        seed = $urandom(32'd20251);

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #0.5;
        // R12: idle after reset
        check(out_valid == 1'b0, "R12", "out_valid after reset", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R12", "in_ready after reset", 64'(in_ready), 64'd1);

        // R2: four contiguous writes form one burst of 4
        cur_req = "R2";
        for (int i = 0; i < 4; i++) send(32'h1000 + 32'(i * 8), 4'b0111, 64'hA000 + 64'(i), 8'hFF, 1'b0);
        settle(40);

        // R1: contiguous I/O writes are never merged
        cur_req = "R1";
        for (int i = 0; i < 3; i++) send(32'h2000 + 32'(i * 8), 4'b0011, 64'hB000 + 64'(i), 8'h0F, 1'b0);
        settle(40);

        // R3: descending address starts a new burst
        cur_req = "R3";
        send(32'h3008, 4'b0111, 64'hC1, 8'hFF, 1'b0);
        send(32'h3000, 4'b0111, 64'hC2, 8'hF0, 1'b0);
        send(32'h3008, 4'b0111, 64'hC3, 8'h3C, 1'b0);
        settle(40);

        // R4: rewrite of a held address keeps old data in the first burst
        cur_req = "R4";
        send(32'h4000, 4'b0111, 64'hD1, 8'hFF, 1'b0);
        send(32'h4008, 4'b0111, 64'hD2, 8'hFF, 1'b0);
        send(32'h4000, 4'b0111, 64'hD3, 8'h01, 1'b0);
        settle(40);

        // R5: barrier splits contiguous writes
        cur_req = "R5";
        send(32'h5000, 4'b1111, 64'hE1, 8'hFF, 1'b0);
        send(32'h5008, 4'b1111, 64'hE2, 8'hFF, 1'b1);
        send(32'h5010, 4'b1111, 64'hE3, 8'hFF, 1'b0);
        settle(40);

        // R8: command type change splits contiguous writes
        cur_req = "R8";
        send(32'h6000, 4'b0111, 64'hF1, 8'hFF, 1'b0);
        send(32'h6008, 4'b1111, 64'hF2, 8'hFF, 1'b0);
        settle(40);

        // R11: misaligned memory write goes alone
        cur_req = "R11";
        send(32'h7000, 4'b0111, 64'h71, 8'hFF, 1'b0);
        send(32'h7008, 4'b0111, 64'h72, 8'hFF, 1'b0);
        send(32'h7014, 4'b0111, 64'h73, 8'h0F, 1'b0);
        settle(40);

        // R6: ten contiguous writes give 8 + 2
        cur_req = "R6";
        for (int i = 0; i < 10; i++) send(32'h8000 + 32'(i * 8), 4'b0111, 64'h8800 + 64'(i), 8'(i + 1), 1'b0);
        settle(40);

        // R7: idle flush exactly after the 16th quiet edge
        cur_req = "R7";
        rdy_mode = 1;
        send(32'h9000, 4'b0111, 64'h99, 8'hFF, 1'b0);
        model_close();
        repeat (16) @(negedge clk);
        #0.6;
        check(out_valid == 1'b0, "R7", "out_valid before idle limit", 64'(out_valid), 64'd0);
        @(negedge clk);
        #0.6;
        check(out_valid == 1'b1, "R7", "out_valid at idle limit", 64'(out_valid), 64'd1);
        settle(10);

        // R10: input held off while a burst waits downstream
        cur_req = "R10";
        rdy_mode = 0;
        send(32'hA000, 4'b0011, 64'hAA, 8'hFF, 1'b0);
        @(negedge clk);
        #0.6;
        check(out_valid == 1'b1, "R10", "out_valid during stall", 64'(out_valid), 64'd1);
        check(in_ready == 1'b0, "R10", "in_ready during drain", 64'(in_ready), 64'd0);
        repeat (3) @(negedge clk);
        #0.6;
        check(in_ready == 1'b0, "R10", "in_ready still low", 64'(in_ready), 64'd0);
        rdy_mode = 1;
        settle(10);

        // R9: random mix under random backpressure
        cur_req = "R9";
        rdy_mode = 2;
        ra = 32'h10000;
        for (int n = 0; n < 400; n++) begin
            pick = $urandom_range(0, 99);
            if (pick < 60)      ra = ra + 32'd8;
            else if (pick < 75) ra = 32'h10000 + (32'($urandom_range(0, 255)) << 3);
            else if (pick < 85) ra = ra - 32'd8;
            else if (pick < 90) ra = ra + 32'd4;
            pick = $urandom_range(0, 99);
            rc = (pick < 75) ? 4'b0111 : ((pick < 90) ? 4'b1111 : 4'b0011);
            send(ra, rc, {$urandom, $urandom}, 8'($urandom_range(1, 255)),
                 ($urandom_range(0, 9) == 0));
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end
        settle(80);
        check(exp_q.size() == 0, "R9", "beats still owed", 64'(exp_q.size()), 64'd0);

        finish_up();
    end

endmodule